// File: doc/BRIEF.md
# Stereo PCM Error Concealment and Muting Stage

This block sits after the error-correction stage of a compact-disc audio path. Bytes arrive on a byte-wide strobed bus. Each channel's sample is carried by three bytes: an error-pointer byte first, then the low data byte, then the high data byte. The left channel comes first in each frame and the right channel follows. The block rebuilds a 16-bit two's-complement sample for each channel. It then hides samples that the pointer marks as bad, using look-ahead: each channel keeps one sample in reserve, so the next value is known before a decision is made.

A bad sample that is followed by a good one becomes the mean of the last value sent and that good sample. A bad sample that is followed by another bad one repeats the last value sent. So a lone error is averaged, and a long burst is held and then averaged back into the good data.

The concealed pair then goes through a level stage:
- -12 dB attenuation, done as an arithmetic shift right by two.
- Hard mute.
- Zero-cross mute, which waits until the sample's top six bits are all ones before it silences.

A left/right clock picks which channel appears on the registered output.

Top module: `pcm_conceal_mute`

## Requirements
- R1: A channel's sample is the bytes pointer, low, high, and the data value is {high, low}. Left is sent first in every frame, right second. The sample is flagged when the pointer byte is non-zero. A good sample appears unchanged once the next sample of the same channel has been received, and the channel's concealed value does not change while no byte is strobed.
- R2: A flagged sample whose next sample is good becomes floor((previous output value + next sample) / 2). This covers a single error between two good samples, including negative values.
- R3: A flagged sample whose next sample is also flagged repeats the channel's previous output value.
- R4: At the end of a held run, the last flagged sample becomes floor((held value + following good sample) / 2).
- R5: The output register takes the left channel when lrck is 1 and the right channel when lrck is 0. It updates one clock after its inputs.
- R6: With att_en=0 and mute=0 the selected sample passes unchanged.
- R7: With att_en=0, mute=1 and zc_en=0 the output is 0.
- R8: With att_en=1 the output is the sample arithmetically shifted right by 2, whatever mute is.
- R9: With att_en=0, mute=1 and zc_en=1, a channel's output passes until its sample has bits 15:10 all ones. From then on it is 0 until mute or zc_en goes low.
- R10: After reset the output is 0. Both channels hold 0, and the reserved sample is 0 and marked good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Strobe for byte_in |
| byte_in | input | 8 | Pointer or data byte |
| lrck | input | 1 | 1 selects left, 0 selects right |
| att_en | input | 1 | -12 dB attenuation enable |
| mute | input | 1 | Mute request |
| zc_en | input | 1 | Defer mute to a sample with top bits all ones |
| sample_out | output | 16 | Processed sample of the selected channel |

## Verification
The assertions check on every cycle the level-stage rules that follow from the control inputs alone:
- hard mute gives zero;
- attenuation stays within a quarter of full scale;
- pass-through tracks the selected concealed word;
- a sample with all-ones top bits under zero-cross mute gives zero;
- concealed words stay still when no byte is strobed.

Only the bench's scenarios can show the rest. That covers the averaging and holding across flagged runs, which depend on samples seen several frames earlier. It also covers floor rounding of negative means, the byte order of a sample, and the zero-cross mute staying on after the sample leaves its trigger range.

// File: rtl/pcm_cm_pkg.sv
package pcm_cm_pkg;
  typedef enum logic [1:0] {
    GATE_PASS,
    GATE_SILENT,
    GATE_ATTEN
  } gate_mode_t;
endpackage

// File: rtl/pcm_byte_framer.sv
module pcm_byte_framer #(
  parameter int BW  = 8,
  parameter int DW  = 16,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_vld,
  input  logic [BW-1:0]  byte_in,
  output logic [NCH-1:0] word_vld,
  output logic [DW-1:0]  word_data,
  output logic           word_flag
);
  localparam int BPS = DW / BW + 1;
  localparam int SW  = $clog2(BPS);
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int AW  = DW - BW;

  logic [SW-1:0] slot_q, slot_d;
  logic [CW-1:0] chan_q, chan_d;
  logic [AW-1:0] acc_q, acc_d;
  logic          flag_q, flag_d;
  logic          last_slot, last_chan;

  assign last_slot = (slot_q == SW'(BPS - 1));
  assign last_chan = (chan_q == CW'(NCH - 1));

  always_comb begin
    slot_d = slot_q;
    chan_d = chan_q;
    acc_d  = acc_q;
    flag_d = flag_q;
    if (byte_vld) begin
      if (slot_q == '0) flag_d = |byte_in;
      else if (!last_slot) acc_d = AW'({byte_in, acc_q} >> BW);
      if (last_slot) begin
        slot_d = '0;
        chan_d = last_chan ? '0 : CW'(chan_q + 1'b1);
      end else begin
        slot_d = SW'(slot_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      chan_q <= '0;
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else if (byte_vld) begin
      slot_q <= slot_d;
      chan_q <= chan_d;
      acc_q  <= acc_d;
      flag_q <= flag_d;
    end
  end

  assign word_data = {byte_in, acc_q};
  assign word_flag = flag_q;

  for (genvar c = 0; c < NCH; c++) begin : g_vld
    assign word_vld[c] = byte_vld && last_slot && (chan_q == CW'(c));
  end
endmodule

// File: rtl/pcm_hole_filler.sv
module pcm_hole_filler #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_word,
  input  logic          in_flag,
  output logic [DW-1:0] out_word
);
  logic [DW-1:0] pend_q, out_q, out_d;
  logic          pend_bad_q;
  logic [DW:0]   pair_sum;

  assign pair_sum = {out_q[DW-1], out_q} + {in_word[DW-1], in_word};

  always_comb begin
    if (!pend_bad_q)  out_d = pend_q;
    else if (in_flag) out_d = out_q;
    else              out_d = pair_sum[DW:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_bad_q <= 1'b0;
      out_q      <= '0;
    end else if (in_vld) begin
      pend_q     <= in_word;
      pend_bad_q <= in_flag;
      out_q      <= out_d;
    end
  end

  assign out_word = out_q;
endmodule

// File: rtl/pcm_level_gate.sv
module pcm_level_gate
  import pcm_cm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NCH     = 2,
  parameter int SHIFT   = 2,
  parameter int ZC_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0][DW-1:0]  chan_words,
  input  logic                    lrck,
  input  logic                    att_en,
  input  logic                    mute,
  input  logic                    zc_en,
  output logic [DW-1:0]           sample_out
);
  localparam int LEFT  = 0;
  localparam int RIGHT = NCH - 1;

  logic [NCH-1:0] top_ones, hold_q, hold_d;
  logic [DW-1:0]  sel_word, out_q, out_d;
  logic           sel_top, sel_hold;
  gate_mode_t     mode;

  for (genvar c = 0; c < NCH; c++) begin : g_zc
    assign top_ones[c] = &chan_words[c][DW-1 -: ZC_BITS];
    assign hold_d[c]   = mute && zc_en && (hold_q[c] || top_ones[c]);
  end

  assign sel_word = lrck ? chan_words[LEFT] : chan_words[RIGHT];
  assign sel_top  = lrck ? top_ones[LEFT]   : top_ones[RIGHT];
  assign sel_hold = lrck ? hold_q[LEFT]     : hold_q[RIGHT];

  always_comb begin
    if (att_en) mode = GATE_ATTEN;
    else if (mute && (!zc_en || sel_hold || sel_top)) mode = GATE_SILENT;
    else mode = GATE_PASS;
  end

  always_comb begin
    case (mode)
      GATE_ATTEN:  out_d = DW'($signed(sel_word) >>> SHIFT);
      GATE_SILENT: out_d = '0;
      default:     out_d = sel_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign sample_out = out_q;
endmodule

// File: rtl/pcm_conceal_mute.sv
module pcm_conceal_mute #(
  parameter int BW      = 8,
  parameter int DW      = 16,
  parameter int NCH     = 2,
  parameter int SHIFT   = 2,
  parameter int ZC_BITS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_in,
  input  logic          lrck,
  input  logic          att_en,
  input  logic          mute,
  input  logic          zc_en,
  output logic [DW-1:0] sample_out
);
  logic [NCH-1:0]         word_vld;
  logic [DW-1:0]          word_data;
  logic                   word_flag;
  logic [NCH-1:0][DW-1:0] chan_words;

  pcm_byte_framer #(.BW(BW), .DW(DW), .NCH(NCH)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .word_vld  (word_vld),
    .word_data (word_data),
    .word_flag (word_flag)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_fill
    pcm_hole_filler #(.DW(DW)) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (word_vld[c]),
      .in_word  (word_data),
      .in_flag  (word_flag),
      .out_word (chan_words[c])
    );
  end

  pcm_level_gate #(.DW(DW), .NCH(NCH), .SHIFT(SHIFT), .ZC_BITS(ZC_BITS)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_words (chan_words),
    .lrck       (lrck),
    .att_en     (att_en),
    .mute       (mute),
    .zc_en      (zc_en),
    .sample_out (sample_out)
  );
endmodule

// File: rtl/pcm_conceal_mute_chk.sv
module pcm_conceal_mute_chk #(
  parameter int DW      = 16,
  parameter int NCH     = 2,
  parameter int ZC_BITS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   byte_vld,
  input logic                   lrck,
  input logic                   att_en,
  input logic                   mute,
  input logic                   zc_en,
  input logic [NCH-1:0][DW-1:0] chan_words,
  input logic [DW-1:0]          sample_out
);
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(chan_words)); // R1

  AST_PASS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!att_en && !mute && lrck) |=> (sample_out == $past(chan_words[0]))); // R5

  AST_PASS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!att_en && !mute && !lrck) |=> (sample_out == $past(chan_words[NCH-1]))); // R6

  AST_HARD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!att_en && mute && !zc_en) |=> (sample_out == '0)); // R7

  AST_ATTEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    att_en |=> (sample_out[DW-1 -: 3] == {3{sample_out[DW-1]}})); // R8

  AST_ZC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!att_en && mute && zc_en && lrck && (&chan_words[0][DW-1 -: ZC_BITS]))
      |=> (sample_out == '0)); // R9
endmodule

bind pcm_conceal_mute pcm_conceal_mute_chk #(.DW(DW), .NCH(NCH), .ZC_BITS(ZC_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .lrck       (lrck),
  .att_en     (att_en),
  .mute       (mute),
  .zc_en      (zc_en),
  .chan_words (chan_words),
  .sample_out (sample_out)
);

// File: tb/sim_pcm_conceal_mute.sv
`timescale 1ns/1ps
module sim_pcm_conceal_mute;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        lrck = 1'b1;
  logic        att_en = 1'b0;
  logic        mute = 1'b0;
  logic        zc_en = 1'b0;
  logic [15:0] sample_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_conceal_mute u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .lrck(lrck), .att_en(att_en), .mute(mute), .zc_en(zc_en),
    .sample_out(sample_out)
  );

  // behavioural reference model
  logic signed [15:0] m_conc [2];
  logic signed [15:0] m_pend [2];
  bit                 m_pbad [2];
  bit                 m_zh [2];
  logic [7:0]         m_lo;
  bit                 m_inbad;
  int                 m_cnt;
  logic signed [15:0] exp_out;

  function automatic bit top6(logic [15:0] v);
    return v[15:10] == 6'h3F;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_conc[c] = '0; m_pend[c] = '0; m_pbad[c] = 0; m_zh[c] = 0;
      end
      m_lo = '0; m_inbad = 0; m_cnt = 0; exp_out = '0;
    end else begin
      int ch;
      int s;
      logic signed [15:0] v, e, w;
      ch = lrck ? 0 : 1;
      v = m_conc[ch];
      if (att_en) e = v >>> 2;
      else if (mute && (!zc_en || m_zh[ch] || top6(v))) e = '0;
      else e = v;
      for (int c = 0; c < 2; c++)
        m_zh[c] = mute && zc_en && (m_zh[c] || top6(m_conc[c]));
      if (byte_vld) begin
        ch = m_cnt / 3;
        case (m_cnt % 3)
          0: m_inbad = (byte_in != 0);
          1: m_lo = byte_in;
          default: begin
            w = {byte_in, m_lo};
            if (m_pbad[ch]) begin
              if (!m_inbad) begin
                s = int'(m_conc[ch]) + int'(w);
                m_conc[ch] = 16'(s >>> 1);
              end
            end else begin
              m_conc[ch] = m_pend[ch];
            end
            m_pend[ch] = w;
            m_pbad[ch] = m_inbad;
          end
        endcase
        m_cnt = (m_cnt + 1) % 6;
      end
      exp_out = e;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (sample_out !== exp_out) begin
        bad++;
        $display("FAIL R1/R5 cycle model act=%0d exp=%0d", $signed(sample_out), exp_out);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, $signed(act), $signed(expv));
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
  endtask

  task automatic frame(logic [7:0] pl, logic [15:0] l, logic [7:0] pr, logic [15:0] r);
    put(pl); put(l[7:0]); put(l[15:8]);
    put(pr); put(r[7:0]); put(r[15:8]);
    @(negedge clk);
    byte_vld = 1'b0;
    byte_in  = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic see_left(string tag, logic [15:0] expv);
    lrck = 1'b1;
    settle();
    chk(tag, sample_out, expv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset output", sample_out, 16'd0);
    rst_n = 1'b1;
    settle();
    chk("R10 after release", sample_out, 16'd0);

    // R2: single error between good samples
    frame(8'h00, 16'd100, 8'h00, 16'd1000);
    frame(8'h01, 16'd999, 8'h00, 16'd1001);
    frame(8'h00, 16'd300, 8'h00, 16'd1002);
    see_left("R2 mean of neighbours", 16'd200);
    lrck = 1'b0;
    settle();
    chk("R5 right channel on lrck low", sample_out, 16'd1001);

    // R3/R4: burst of four flagged samples
    frame(8'h80, 16'd7, 8'h00, 16'd1003);
    frame(8'h80, 16'd7, 8'h00, 16'd1004);
    frame(8'h80, 16'd7, 8'h00, 16'd1005);
    see_left("R3 held value in burst", 16'd300);
    frame(8'h80, 16'd7, 8'h00, 16'd1006);
    frame(8'h00, 16'd500, 8'h00, 16'd1007);
    see_left("R4 mean closing a burst", 16'd400);
    frame(8'h00, 16'd600, 8'h00, 16'd1008);
    see_left("R1 good sample unchanged", 16'd500);

    // R2 with negative values (floor)
    frame(8'h00, -16'sd100, 8'h00, 16'd1009);
    frame(8'h02, 16'd5, 8'h00, 16'd1010);
    frame(8'h00, -16'sd301, 8'h00, 16'd1011);
    see_left("R2 negative mean floors", -16'sd201);

    // R1 byte order {high, low}
    frame(8'h00, 16'h1234, 8'h00, 16'd1012);
    frame(8'h00, 16'd500, 8'h00, 16'd1013);
    see_left("R1 high byte after low byte", 16'h1234);
    frame(8'h00, 16'd500, 8'h00, 16'd1014);
    see_left("R6 pass through", 16'd500);

    // level stage
    mute = 1'b1;
    see_left("R7 hard mute", 16'd0);
    att_en = 1'b1;
    see_left("R8 attenuation with mute", 16'd125);
    mute = 1'b0;
    see_left("R8 attenuation without mute", 16'd125);
    att_en = 1'b0;
    see_left("R6 back to pass", 16'd500);

    // R9 zero-cross mute
    zc_en = 1'b1; mute = 1'b1;
    see_left("R9 deferred while top bits not ones", 16'd500);
    frame(8'h00, 16'hFFFB, 8'h00, 16'd1015);
    frame(8'h00, 16'd500, 8'h00, 16'd1016);
    see_left("R9 silenced at all-ones top", 16'd0);
    frame(8'h00, 16'd500, 8'h00, 16'd1017);
    see_left("R9 silence persists", 16'd0);
    mute = 1'b0;
    see_left("R9 release on mute low", 16'd500);
    mute = 1'b1;
    see_left("R9 re-armed and deferred", 16'd500);
    mute = 1'b0; zc_en = 1'b0;

    // R8 negative attenuation
    frame(8'h00, -16'sd400, 8'h00, 16'd1018);
    frame(8'h00, 16'd0, 8'h00, 16'd1019);
    att_en = 1'b1;
    see_left("R8 negative shift", -16'sd100);
    att_en = 1'b0;
    lrck = 1'b0;
    settle();
    chk("R5 right after traffic", sample_out, 16'd1018);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule